// File: doc/BRIEF.md
# Programmable Timer / Counter / PWM Block

This block is one configurable digital cell built around a down-counter. Software sets it up through a small byte-wide write port: a period value, a compare value, a control byte that selects the operating mode, an enable bit and an output inversion, plus two routing bytes. The routing bytes pick the counting clock and the way that clock is brought into the system clock domain. In timer mode the counter runs freely and emits a one-clock terminal-count pulse at each reload. In counter mode it advances only while a gate input is high. In PWM mode the primary output is high while the count is below the compare value, so the duty cycle is the compare value over the period length.

A capture strobe copies the live count into a snapshot register that software reads at address 0. A single interrupt line can follow either the terminal-count pulse or the rising edge of the compare condition. The selected counting tick is also driven out so that a neighbouring cell can use it as its own clock source.

Top module: `ptc_block`

## Requirements
- R1: After reset every readable register returns 0, the count is 0, the block is disabled, and `out_o` and `irq_o` are low.
- R2: The write addresses are 1 for period, 2 for compare, 3 for control (bits 4..0 kept: bit0 enable, bits 2..1 mode with 00 timer, 01 counter, 1x PWM, bit3 interrupt source, bit4 invert), 4 for clock select (bits 3..0 kept) and 5 for resync select (bits 7..6 kept). Each of these reads back with the bits that are not kept reading as 0. Address 0 reads the capture snapshot, and writes to address 0 are ignored. Addresses 6 and 7 read as 0.
- R3: On each tick while enabled, a nonzero count decrements by one and a zero count reloads the period. The terminal-count pulse is high for exactly the one clock in which the reloaded value is shown.
- R4: While disabled the count holds, and a period write also loads the count on the same edge.
- R5: In counter mode the count advances only on ticks where `gate_i` is high.
- R6: In PWM mode `out_o` is high while count < compare. A compare value of 0 gives a constant low, and a compare value above the period gives a constant high.
- R7: Control bit4 inverts `out_o` in every mode.
- R8: With control bit3 = 0, `irq_o` equals the terminal-count pulse. With bit3 = 1, `irq_o` pulses for one clock when count < compare becomes true. `irq_o` is low while the block is disabled.
- R9: A clock with `capture_i` high copies the current count into the snapshot that address 0 returns.
- R10: Clock source 0 ticks every clock. Source 1 ticks every second clock. Sources 2..15 tick on rising edges of `ext_src[0..13]`.
- R11: With resync select 00, a rising edge on an external source advances the count at the first clock edge that samples it high.
- R12: With resync select 10 or 11, the edge passes through a two-flop synchronizer and advances the count two clocks later than with 00.
- R13: With resync select 01, ticks are issued only on base-rate phase clocks. An edge arriving off-phase is held until the next phase clock, so no edge is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (double-rate clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Combinational read data |
| ext_src | input | 14 | External clock candidates (sources 2..15) |
| gate_i | input | 1 | Count gate used in counter mode |
| capture_i | input | 1 | Capture strobe |
| count_o | output | 8 | Live count |
| tick_o | output | 1 | Selected counting tick, offered to a neighbour |
| out_o | output | 1 | Primary output (terminal count or PWM) |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The hardest case to reach is the base-rate resync path. There, an external edge that lands on the off phase must be held in a pending flag and released on the following phase clock, and the phase itself is not visible at the ports. The bench sends a train of external pulses whose spacing is not a multiple of two, so edges fall on both phases. It then checks that the count dropped by exactly the number of pulses. The ordinary modes are driven by a long seeded random run that changes period, compare, mode, gate and capture, and a cycle model checks the run on every clock.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CAP  = 3'd0;
  localparam logic [ADDR_W-1:0] A_PER  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CSEL = 3'd4;
  localparam logic [ADDR_W-1:0] A_OSEL = 3'd5;

  typedef enum logic [1:0] {
    MD_TIMER = 2'b00,
    MD_COUNT = 2'b01,
    MD_PWM   = 2'b10,
    MD_PWMX  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SY_NONE  = 2'b00,
    SY_BASE  = 2'b01,
    SY_FAST  = 2'b10,
    SY_FASTX = 2'b11
  } sync_e;

  typedef struct packed {
    logic  inv;
    logic  irq_cmp;
    mode_e mode;
    logic  en;
  } ctl_t;
endpackage

// File: rtl/ptc_regs.sv
module ptc_regs
  import ptc_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned NSRC = 16,
  localparam int unsigned SW  = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              capture,
  input  logic [W-1:0]      cap_val,
  output logic [W-1:0]      rd_data,
  output logic [W-1:0]      per,
  output logic [W-1:0]      cmp,
  output ctl_t              ctl,
  output logic [SW-1:0]     csel,
  output sync_e             sync,
  output logic              per_wr
);
  logic [W-1:0] cap;
  logic [4:0]   ctl_bits;
  logic [1:0]   osel;

  assign per_wr = wr_en && (wr_addr == A_PER);
  assign ctl    = ctl_t'(ctl_bits);
  assign sync   = sync_e'(osel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per      <= '0;
      cmp      <= '0;
      ctl_bits <= '0;
      csel     <= '0;
      osel     <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PER:   per      <= wr_data;
        A_CMP:   cmp      <= wr_data;
        A_CTL:   ctl_bits <= wr_data[4:0];
        A_CSEL:  csel     <= wr_data[SW-1:0];
        A_OSEL:  osel     <= wr_data[W-1 -: 2];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cap <= '0;
    else if (capture) cap <= cap_val;
  end

  always_comb begin
    case (rd_addr)
      A_CAP:   rd_data = cap;
      A_PER:   rd_data = per;
      A_CMP:   rd_data = cmp;
      A_CTL:   rd_data = W'(ctl_bits);
      A_CSEL:  rd_data = W'(csel);
      A_OSEL:  rd_data = {osel, {(W-2){1'b0}}};
      default: rd_data = '0;
    endcase
  end

  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> cap == $past(cap_val));
  a_r2_cap_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && wr_en && wr_addr == A_CAP) |=> $stable(cap));
endmodule

// File: rtl/ptc_tick.sv
module ptc_tick
  import ptc_pkg::*;
#(
  parameter int unsigned NSRC = 16,
  localparam int unsigned SW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW-1:0]   sel,
  input  sync_e           sync,
  input  logic [NSRC-3:0] ext,
  output logic            tick
);
  logic            phase;
  logic [NSRC-1:0] lv;
  logic            raw, raw_q, s1, s2, s3, pend;
  logic            is_ext, int_ev, ext_ev, ev, base;

  assign lv     = {ext, 2'b00};
  assign raw    = lv[sel];
  assign is_ext = (sel >= SW'(2));
  assign int_ev = (sel == SW'(0)) || ((sel == SW'(1)) && phase);
  assign ext_ev = (sync == SY_NONE) ? (raw && !raw_q) : (s2 && !s3);
  assign ev     = is_ext ? ext_ev : int_ev;
  assign base   = (sync == SY_BASE);
  assign tick   = base ? (phase && (ev || pend)) : ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 1'b0;
      raw_q <= 1'b0;
      s1    <= 1'b0;
      s2    <= 1'b0;
      s3    <= 1'b0;
      pend  <= 1'b0;
    end else begin
      phase <= !phase;
      raw_q <= raw;
      s1    <= raw;
      s2    <= s1;
      s3    <= s2;
      pend  <= base && !phase && (pend || ev);
    end
  end

  a_r13_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (base && ev && !phase) |=> (sync != SY_BASE || tick));
  a_r12_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ext && sync[1] && tick) |-> $past(raw, 2));
endmodule

// File: rtl/ptc_core.sv
module ptc_core
  import ptc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         gate,
  input  logic [W-1:0] per,
  input  logic [W-1:0] cmp,
  input  ctl_t         ctl,
  input  logic         per_wr,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         out,
  output logic         irq
);
  logic adv, tc_q, cmp_lvl, cprev, pwm;

  assign adv     = ctl.en && tick && (ctl.mode != MD_COUNT || gate);
  assign cmp_lvl = (cnt < cmp);
  assign pwm     = ctl.mode[1];
  assign out     = ctl.inv ^ (pwm ? cmp_lvl : tc_q);
  assign irq     = ctl.en && (ctl.irq_cmp ? (cmp_lvl && !cprev) : tc_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      tc_q  <= 1'b0;
      cprev <= 1'b0;
    end else begin
      if (adv)                    cnt <= (cnt == '0) ? per : cnt - 1'b1;
      else if (!ctl.en && per_wr) cnt <= load_val;
      tc_q  <= adv && (cnt == '0);
      cprev <= cmp_lvl;
    end
  end

  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt == '0) |=> cnt == $past(per));
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.en && !per_wr) |=> $stable(cnt));
  a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.mode == MD_COUNT && !gate) |=> $stable(cnt) || $past(per_wr));
  a_r3_tc_source: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |-> $past(cnt) == '0);
endmodule

// File: rtl/ptc_block.sv
module ptc_block
  import ptc_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned NSRC = 16,
  localparam int unsigned SW  = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  input  logic [NSRC-3:0]   ext_src,
  input  logic              gate_i,
  input  logic              capture_i,
  output logic [W-1:0]      count_o,
  output logic              tick_o,
  output logic              out_o,
  output logic              irq_o
);
  logic [W-1:0]  per, cmp;
  ctl_t          ctl;
  logic [SW-1:0] csel;
  sync_e         sync;
  logic          per_wr;

  ptc_regs #(.W(W), .NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .capture(capture_i),
    .cap_val(count_o), .rd_data(rd_data), .per(per), .cmp(cmp),
    .ctl(ctl), .csel(csel), .sync(sync), .per_wr(per_wr)
  );

  ptc_tick #(.NSRC(NSRC)) u_tick (
    .clk(clk), .rst_n(rst_n), .sel(csel), .sync(sync),
    .ext(ext_src), .tick(tick_o)
  );

  ptc_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_o), .gate(gate_i),
    .per(per), .cmp(cmp), .ctl(ctl), .per_wr(per_wr),
    .load_val(wr_data), .cnt(count_o), .out(out_o), .irq(irq_o)
  );

  a_r8_irq_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |-> !irq_o);
endmodule

// File: tb/test_ptc_block.sv
module test_ptc_block;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [13:0] ext_src = '0;
  logic       gate_i = 1'b0;
  logic       capture_i = 1'b0;
  logic [7:0] count_o;
  logic       tick_o, out_o, irq_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ptc_block i_ptc_block (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ext_src(ext_src), .gate_i(gate_i), .capture_i(capture_i),
    .count_o(count_o), .tick_o(tick_o), .out_o(out_o), .irq_o(irq_o)
  );

  // cycle model of the requirements, valid while clock source 0 / resync 00
  logic [7:0] m_cnt, m_per, m_cmp, m_cap;
  logic [4:0] m_ctl;
  logic       m_tc, m_cprev;

  function automatic logic m_adv(logic [4:0] c, logic g);
    return c[0] && (c[2:1] != 2'b01 || g);
  endfunction
  function automatic logic exp_out(logic [4:0] c, logic [7:0] n, logic [7:0] p, logic t);
    return c[4] ^ (c[2] ? (n < p) : t);
  endfunction
  function automatic logic exp_irq(logic [4:0] c, logic [7:0] n, logic [7:0] p, logic t, logic cp);
    return c[0] && (c[3] ? ((n < p) && !cp) : t);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '0; m_per <= '0; m_cmp <= '0; m_cap <= '0;
      m_ctl <= '0; m_tc <= 1'b0; m_cprev <= 1'b0;
    end else begin
      if (wr_en && wr_addr == 3'd1) m_per <= wr_data;
      if (wr_en && wr_addr == 3'd2) m_cmp <= wr_data;
      if (wr_en && wr_addr == 3'd3) m_ctl <= wr_data[4:0];
      if (m_adv(m_ctl, gate_i)) m_cnt <= (m_cnt == 0) ? m_per : m_cnt - 8'd1;
      else if (!m_ctl[0] && wr_en && wr_addr == 3'd1) m_cnt <= wr_data;
      m_tc <= m_adv(m_ctl, gate_i) && (m_cnt == 0);
      m_cprev <= (m_cnt < m_cmp);
      if (capture_i) m_cap <= m_cnt;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (out_o) hi++;
    end
  endtask

  task automatic count_irq(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_o) hi++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int c0, hi;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) rd_chk("R1", 3'(a), 0);
    chk("R1 count", count_o, 0);
    chk("R1 out", out_o, 0);
    chk("R1 irq", irq_o, 0);

    // random run against the model (source 0, resync 00)
    rd_addr = 3'd0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      #1;
      chk("R3 count", count_o, m_cnt);
      chk("R6 out", out_o, exp_out(m_ctl, m_cnt, m_cmp, m_tc));
      chk("R8 irq", irq_o, exp_irq(m_ctl, m_cnt, m_cmp, m_tc, m_cprev));
      chk("R9 capture", rd_data, m_cap);
      gate_i = 1'($urandom_range(0, 1));
      capture_i = ($urandom_range(0, 7) == 0);
      wr_en = ($urandom_range(0, 5) == 0);
      case ($urandom_range(0, 3))
        0: begin wr_addr = 3'd1; wr_data = 8'($urandom_range(0, 15)); end
        1: begin wr_addr = 3'd2; wr_data = 8'($urandom_range(0, 18)); end
        2: begin wr_addr = 3'd3;
                 wr_data = 8'({$urandom_range(0, 7), ($urandom_range(0, 4) != 0)}); end
        default: begin wr_addr = 3'd0; wr_data = 8'($urandom); end
      endcase
    end
    wr_en = 1'b0; capture_i = 1'b0; gate_i = 1'b0;

    // fresh reset for directed cases
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    // R4 disabled hold and load on period write
    wr(3'd1, 8'd9);
    chk("R4 load", count_o, 9);
    repeat (5) @(negedge clk);
    chk("R4 hold", count_o, 9);

    // R3 down-count, reload and terminal count
    wr(3'd1, 8'd3);
    wr(3'd3, 8'h01);
    chk("R3 start", count_o, 3);
    @(negedge clk); chk("R3 dec", count_o, 2);
    @(negedge clk); chk("R3 dec", count_o, 1);
    @(negedge clk); chk("R3 dec", count_o, 0); chk("R3 tc low", out_o, 0);
    @(negedge clk); chk("R3 reload", count_o, 3); chk("R3 tc", out_o, 1);
    chk("R8 irq tc", irq_o, 1);
    @(negedge clk); chk("R3 tc one clock", out_o, 0);

    // R8 compare-sourced interrupt: per 3, cmp 2 -> one pulse every 4 clocks
    wr(3'd2, 8'd2);
    wr(3'd3, 8'h09);
    count_irq(8, hi);
    chk("R8 irq cmp", hi, 2);

    // R6 PWM
    wr(3'd1, 8'd4);
    wr(3'd3, 8'h05);
    wr(3'd2, 8'd0);
    count_high(10, hi); chk("R6 zero duty", hi, 0);
    wr(3'd2, 8'd5);
    count_high(10, hi); chk("R6 full duty", hi, 10);
    wr(3'd2, 8'd2);
    count_high(10, hi); chk("R6 2/5 duty", hi, 4);
    // R7 inversion
    wr(3'd2, 8'd0);
    wr(3'd3, 8'h15);
    count_high(10, hi); chk("R7 inverted", hi, 10);

    // R5 counter mode gate
    wr(3'd3, 8'h00);
    wr(3'd1, 8'd20);
    wr(3'd3, 8'h03);
    repeat (5) @(negedge clk);
    chk("R5 gate low", count_o, 20);
    gate_i = 1'b1;
    @(negedge clk); chk("R5 gate high", count_o, 19);
    gate_i = 1'b0;

    // R10 half-rate source
    wr(3'd3, 8'h00);
    wr(3'd1, 8'd50);
    wr(3'd4, 8'd1);
    wr(3'd3, 8'h01);
    c0 = count_o;
    repeat (20) @(negedge clk);
    chk("R10 half rate", count_o, c0 - 10);

    // R11 external source, no resync
    wr(3'd3, 8'h00);
    wr(3'd1, 8'd50);
    wr(3'd4, 8'd2);
    wr(3'd3, 8'h01);
    c0 = count_o;
    ext_src[0] = 1'b1;
    @(negedge clk); chk("R11 direct", count_o, c0 - 1);
    @(negedge clk); chk("R11 level", count_o, c0 - 1);
    ext_src[0] = 1'b0;
    repeat (3) @(negedge clk);

    // R12 two-flop resync
    wr(3'd5, 8'h80);
    repeat (3) @(negedge clk);
    c0 = count_o;
    ext_src[0] = 1'b1;
    @(negedge clk); chk("R12 wait1", count_o, c0);
    @(negedge clk); chk("R12 wait2", count_o, c0);
    @(negedge clk); chk("R12 sync", count_o, c0 - 1);
    ext_src[0] = 1'b0;
    repeat (4) @(negedge clk);

    // R13 base-rate resync, pulses land on both phases
    wr(3'd5, 8'h40);
    repeat (4) @(negedge clk);
    c0 = count_o;
    for (int p = 0; p < 8; p++) begin
      ext_src[0] = 1'b1;
      repeat (2) @(negedge clk);
      ext_src[0] = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk("R13 no loss", count_o, c0 - 8);

    // R2 register readback and ignored writes
    wr(3'd3, 8'h00);
    wr(3'd1, 8'h37); rd_chk("R2 period", 3'd1, 8'h37);
    wr(3'd2, 8'h12); rd_chk("R2 compare", 3'd2, 8'h12);
    wr(3'd4, 8'hFF); rd_chk("R2 clksel", 3'd4, 8'h0F);
    wr(3'd5, 8'hFF); rd_chk("R2 resync", 3'd5, 8'hC0);
    wr(3'd3, 8'hE6); rd_chk("R2 control", 3'd3, 8'h06);
    rd_addr = 3'd0; #1; c0 = rd_data;
    wr(3'd0, 8'hAA); rd_chk("R2 addr0 write ignored", 3'd0, c0);
    rd_chk("R2 unused", 3'd6, 0);
    rd_chk("R2 unused", 3'd7, 0);

    finish_run();
  end
endmodule